// File: doc/BRIEF.md
# Sequenced SPI Master with Write-then-Read Transactions

This block is an SPI master with a small register bus. Each transaction is set up once and then runs without further help from software. It is either a write-only burst, or a write burst followed at once by a read burst. Software picks the serial clock divider, pushes the outgoing bytes as 32-bit words, and writes the transfer register with the byte counts, the mode and the start bit. The controller holds chip select low for the whole sequence. It shifts the write bytes out and then clocks the read bytes in, with no second trigger between the two phases.

Outgoing and incoming words pass through one shared data address. A bus write to that address goes into a transmit FIFO. A bus read from it takes a word out of a receive FIFO. Bytes are packed little-endian. If the receive FIFO fills up, the serial clock stops at a byte boundary until software drains a word, so no data is dropped. A soft reset bit stops any transfer in progress and empties both FIFOs.

Top module: `spi_seq_master`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, the status register (address 3) reads 0 and the transfer register (address 2) reads 0.
- R2: The serial clock runs in mode 0: it idles low, both its high half and its low half last BAUD+1 bus clocks, and the period is therefore 2*(BAUD+1) bus clocks. BAUD is bits 7:0 of the divider register (address 1). Data is sent MSB first, and MOSI only changes while the clock is low.
- R3: The transfer register (address 2) has these fields: bit 0 is start, bit 1 is mode (0 = write-only, 1 = write-then-read), bits 15:8 hold the write byte count minus one, and bits 23:16 hold the read byte count minus one. In write-only mode exactly 8*W clock pulses are produced for W write bytes.
- R4: In write-then-read mode, the R read bytes are clocked immediately after the W write bytes, inside a single chip-select low window, with 8*(W+R) pulses in total. Read byte j is the byte the peripheral drives during transaction byte W+j.
- R5: The data register (address 4) is shared. A write pushes into the transmit FIFO and a read pops the receive FIFO. Byte k of a transfer sits in bits 8*(k mod 4)+7 : 8*(k mod 4) of word k/4, and a final partial word uses only its low bytes.
- R6: Status bit 0 is busy, bit 1 is TX-full and bit 2 is RX-data-available. Busy equals the start bit. It is set from the start write until the transaction completes, and the start bit clears itself in that same cycle.
- R7: The transmit FIFO holds 4 words. TX-full is set after 4 pushes with no pops, and a push while full is discarded.
- R8: When the receive FIFO is full, shifting halts before the next byte and resumes after a pop. With W=1 and no pops, the clock stops after 8*(1+20) pulses and busy stays high.
- R9: Writing 1 to bit 0 of the control register (address 0) returns the block to idle in the next cycle: chip select goes high, the clock goes low, busy clears, and both FIFOs are emptied.
- R10: A write to the transfer register while busy is ignored, so the running transaction keeps its counts and mode.
- R11: After the last bit, chip select stays high for at least one serial clock period before busy drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (pops RX at the data address) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from the address |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
An error in the byte counter or the phase flag shows up on the serial pins within one byte time. The pulse count per chip-select window comes out wrong, or the read bytes land at the wrong transaction index. A wrong byte lane in the word packing shows up when the bench compares a word popped from the data register with the bytes the peripheral sent. A broken stall or start-bit path shows up as a pulse count past the stall point, or as busy staying high or falling too early. Either is visible at the status register on the next poll.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

    localparam int WORD_W = 32;
    localparam int CNT_W  = 8;
    localparam int DIV_W  = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_CLKDIV = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_XFER   = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_DATA   = 3'd4;

    typedef enum logic {
        MODE_WRITE      = 1'b0,
        MODE_WRITE_READ = 1'b1
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_LOW,
        ST_HIGH,
        ST_PUSH,
        ST_GAP
    } eng_state_e;

    typedef struct packed {
        logic [CNT_W-1:0] rlast;
        logic [CNT_W-1:0] wlast;
        mode_e            mode;
        logic             start;
    } xfer_cfg_t;

endpackage

// File: rtl/spi_seq_fifo.sv
module spi_seq_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic [CW-1:0]    cnt;
    logic             do_push, do_pop;

    assign full    = (cnt == FULL_CNT);
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R7: occupancy never exceeds the depth
    assert_fifo_bound_R7: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL_CNT);

endmodule

// File: rtl/spi_seq_engine.sv
module spi_seq_engine
    import spi_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  mode_e             mode,
    input  logic [CNT_W-1:0]  wlast,
    input  logic [CNT_W-1:0]  rlast,
    input  logic [DIV_W-1:0]  baud,
    input  logic              tx_avail,
    input  logic [WORD_W-1:0] tx_word,
    output logic              tx_pop,
    input  logic              rx_full,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_push,
    output logic              done,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n,
    input  logic              miso
);
    eng_state_e        state, adv_state;
    logic [DIV_W:0]    div;
    logic [2:0]        bitc;
    logic [CNT_W-1:0]  bytec, adv_bytec;
    logic              rphase, adv_rphase;
    logic [7:0]        sreg;
    logic              rx_bit;
    logic [23:0]       hold;
    logic [WORD_W-1:0] rx_acc;
    logic [1:0]        lane;
    logic              last_byte, half_end, gap_end;
    logic [7:0]        shifted;

    assign lane      = bytec[1:0];
    assign last_byte = rphase ? (bytec == rlast) : (bytec == wlast);
    assign half_end  = (div == {1'b0, baud});
    assign gap_end   = (div == {baud, 1'b1});
    assign shifted   = {sreg[6:0], rx_bit};

    assign tx_pop  = (state == ST_LOAD) && !rphase && (lane == 2'd0) && tx_avail;
    assign rx_push = (state == ST_PUSH) && !rx_full;
    assign rx_word = rx_acc;
    assign done    = (state == ST_GAP) && gap_end;
    assign sclk    = (state == ST_HIGH);
    assign cs_n    = (state == ST_IDLE) || (state == ST_GAP);
    assign mosi    = sreg[7];

    // where to go once a byte is finished
    always_comb begin
        adv_state  = ST_LOAD;
        adv_rphase = rphase;
        adv_bytec  = bytec + 1'b1;
        if (last_byte) begin
            adv_bytec = '0;
            if (!rphase && mode == MODE_WRITE_READ) adv_rphase = 1'b1;
            else                                    adv_state  = ST_GAP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            div    <= '0;
            bitc   <= '0;
            bytec  <= '0;
            rphase <= 1'b0;
            sreg   <= '0;
            rx_bit <= 1'b0;
            hold   <= '0;
            rx_acc <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state  <= ST_LOAD;
                        rphase <= 1'b0;
                        bytec  <= '0;
                        rx_acc <= '0;
                    end
                end
                ST_LOAD: begin
                    div  <= '0;
                    bitc <= '0;
                    if (rphase) begin
                        sreg  <= '0;
                        state <= ST_LOW;
                    end else if (lane != 2'd0) begin
                        sreg  <= hold[7:0];
                        hold  <= {8'h00, hold[23:8]};
                        state <= ST_LOW;
                    end else if (tx_avail) begin
                        sreg  <= tx_word[7:0];
                        hold  <= tx_word[31:8];
                        state <= ST_LOW;
                    end
                end
                ST_LOW: begin
                    if (half_end) begin
                        div    <= '0;
                        rx_bit <= miso;
                        state  <= ST_HIGH;
                    end else begin
                        div <= div + 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (half_end) begin
                        div  <= '0;
                        sreg <= shifted;
                        if (bitc == 3'd7) begin
                            if (rphase) begin
                                rx_acc[{lane, 3'b000} +: 8] <= shifted;
                            end
                            if (rphase && (lane == 2'd3 || last_byte)) begin
                                state <= ST_PUSH;
                            end else begin
                                state  <= adv_state;
                                rphase <= adv_rphase;
                                bytec  <= adv_bytec;
                            end
                        end else begin
                            bitc  <= bitc + 1'b1;
                            state <= ST_LOW;
                        end
                    end else begin
                        div <= div + 1'b1;
                    end
                end
                ST_PUSH: begin
                    div <= '0;
                    if (!rx_full) begin
                        rx_acc <= '0;
                        state  <= adv_state;
                        rphase <= adv_rphase;
                        bytec  <= adv_bytec;
                    end
                end
                ST_GAP: begin
                    if (gap_end) state <= ST_IDLE;
                    else         div   <= div + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: MOSI holds steady across the whole high half of the clock
    assert_mosi_steady_R2: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // R4: the read phase is entered with chip select still low
    assert_read_in_frame_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(rphase) |-> !cs_n);

endmodule

// File: rtl/spi_seq_master.sv
module spi_seq_master
    import spi_seq_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs_n
);
    logic              srst;
    logic [DIV_W-1:0]  baud_q;
    xfer_cfg_t         cfg_q;
    logic              busy;
    logic              tx_push, tx_pop, tx_full, tx_empty;
    logic [WORD_W-1:0] tx_word;
    logic              rx_push, rx_pop, rx_full, rx_empty;
    logic [WORD_W-1:0] rx_word, rx_head;
    logic              eng_done;
    logic              xfer_wr;

    assign srst    = rst || (reg_we && reg_addr == ADDR_CTRL && reg_wdata[0]);
    assign xfer_wr = reg_we && reg_addr == ADDR_XFER;
    assign tx_push = reg_we && reg_addr == ADDR_DATA;
    assign rx_pop  = reg_re && reg_addr == ADDR_DATA;
    assign busy    = cfg_q.start;

    always_ff @(posedge clk) begin
        if (rst) baud_q <= '0;
        else if (reg_we && reg_addr == ADDR_CLKDIV) baud_q <= reg_wdata[DIV_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            cfg_q <= '0;
        end else if (eng_done) begin
            cfg_q.start <= 1'b0;
        end else if (xfer_wr && !cfg_q.start) begin
            cfg_q.start <= reg_wdata[0];
            cfg_q.mode  <= mode_e'(reg_wdata[1]);
            cfg_q.wlast <= reg_wdata[15:8];
            cfg_q.rlast <= reg_wdata[23:16];
        end
    end

    always_comb begin
        case (reg_addr)
            ADDR_CLKDIV: reg_rdata = {{(WORD_W-DIV_W){1'b0}}, baud_q};
            ADDR_XFER:   reg_rdata = {8'h00, cfg_q.rlast, cfg_q.wlast, 6'h00,
                                      cfg_q.mode, cfg_q.start};
            ADDR_STATUS: reg_rdata = {29'h0, !rx_empty, tx_full, busy};
            ADDR_DATA:   reg_rdata = rx_head;
            default:     reg_rdata = '0;
        endcase
    end

    spi_seq_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(srst),
        .push(tx_push), .wdata(reg_wdata),
        .pop(tx_pop), .rdata(tx_word),
        .full(tx_full), .empty(tx_empty)
    );

    spi_seq_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(srst),
        .push(rx_push), .wdata(rx_word),
        .pop(rx_pop), .rdata(rx_head),
        .full(rx_full), .empty(rx_empty)
    );

    spi_seq_engine u_eng (
        .clk(clk), .rst(srst),
        .start(cfg_q.start), .mode(cfg_q.mode),
        .wlast(cfg_q.wlast), .rlast(cfg_q.rlast), .baud(baud_q),
        .tx_avail(!tx_empty), .tx_word(tx_word), .tx_pop(tx_pop),
        .rx_full(rx_full), .rx_word(rx_word), .rx_push(rx_push),
        .done(eng_done),
        .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n), .miso(spi_miso)
    );

    // R8: the engine never offers a word to a full receive queue
    assert_rx_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        rx_push |-> !rx_full);

    // R5: a transmit word is only taken when one is queued
    assert_tx_pop_valid_R5: assert property (@(posedge clk) disable iff (rst)
        tx_pop |-> !tx_empty);

    // R6: without a pending start the bus stays deselected
    assert_idle_deselect_R6: assert property (@(posedge clk) disable iff (rst)
        !busy |-> spi_cs_n);

    // R6: completion clears the start bit on the following cycle
    assert_start_clears_R6: assert property (@(posedge clk) disable iff (rst)
        eng_done |=> !busy);

endmodule

// File: tb/sim_spi_seq_master.sv
module sim_spi_seq_master;
    import spi_seq_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0, reg_re = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        spi_sclk, spi_mosi, spi_miso, spi_cs_n;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc++;

    spi_seq_master u0 (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    function automatic logic [7:0] tx_b(int t, int i);
        return 8'(8'h5A + t * 8'h31 + i * 8'h0D);
    endfunction

    function automatic logic [7:0] resp(int t, int n);
        return 8'(8'hC3 ^ (t * 8'h11) ^ (n * 8'h27));
    endfunction

    function automatic logic [31:0] tx_wd(int t, int k, int w);
        logic [31:0] d = '0;
        for (int b = 0; b < 4; b++)
            if (4 * k + b < w) d[8*b +: 8] = tx_b(t, 4 * k + b);
        return d;
    endfunction

    // peripheral model
    int          cur_t = 0;
    int          rises = 0, frame_rise0 = 0, r1_cyc = 0, per = 0;
    int          cs_falls = 0, cs_rise_cyc = 0;
    logic        cs_prev = 1'b1;
    logic [7:0]  sl_sh = '0, sl_cap = '0;
    logic [7:0]  mosi_log [64];

    assign spi_miso = sl_sh[7];

    always @(posedge spi_sclk) begin
        int b;
        rises++;
        b = rises - frame_rise0;
        if (b == 1) r1_cyc = cyc;
        if (b == 2) per = cyc - r1_cyc;
        sl_cap = {sl_cap[6:0], spi_mosi};
        if (b % 8 == 0 && b / 8 <= 64) mosi_log[b/8-1] = sl_cap;
    end

    always @(negedge spi_sclk or negedge spi_cs_n or posedge spi_cs_n) begin
        int b;
        if (spi_cs_n) begin
            if (!cs_prev) cs_rise_cyc = cyc;
            cs_prev = 1'b1;
        end else if (cs_prev) begin
            cs_prev = 1'b0;
            cs_falls++;
            frame_rise0 = rises;
            sl_sh = resp(cur_t, 0);
        end else begin
            b = rises - frame_rise0;
            if (b % 8 == 0) sl_sh = resp(cur_t, b / 8);
            else            sl_sh = {sl_sh[6:0], 1'b0};
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_re = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    // stimulus table: {flags, mode, write bytes, read bytes, baud}
    // flags bit0: rewrite transfer register while busy; bit1: RX stall probe
    localparam int NV = 8;
    localparam logic [39:0] VEC [NV] = '{
        40'h00_00_01_00_00,
        40'h00_00_05_00_02,
        40'h00_01_01_01_01,
        40'h00_01_03_06_00,
        40'h01_01_04_04_03,
        40'h00_01_09_0D_00,
        40'h00_00_10_00_00,
        40'h02_01_01_18_00
    };

    task automatic run(int t, logic md, int w, int r, int baud, logic [7:0] fl);
        int nw, pushed, got, pre_falls, reads;
        logic [31:0] d, s;
        logic [7:0] rxb [64];
        bit seen_idle;
        cur_t = t;
        reads = md ? r : 0;
        wr(ADDR_CLKDIV, 32'(baud));
        nw = (w + 3) / 4;
        pushed = 0;
        while (pushed < nw && pushed < 4) begin
            wr(ADDR_DATA, tx_wd(t, pushed, w));
            pushed++;
        end
        pre_falls = cs_falls;
        wr(ADDR_XFER, {8'h00, 8'(md ? r - 1 : 0), 8'(w - 1), 6'h00, md, 1'b1});
        rd(ADDR_XFER, d);
        chk("R6 start bit set while running", 32'(d[0]), 32'd1);
        if (fl[0]) begin
            wr(ADDR_XFER, 32'h0000_0001);
        end
        if (fl[1]) begin
            repeat (900) @(negedge clk);
            chk("R8 pulses frozen at stall", 32'(rises - frame_rise0), 32'(8 * (w + 20)));
            rd(ADDR_STATUS, s);
            chk("R8 busy held during stall", 32'(s[0]), 32'd1);
        end
        got = 0;
        seen_idle = 0;
        while (!seen_idle) begin
            rd(ADDR_STATUS, s);
            if (s[2]) begin
                rd(ADDR_DATA, d);
                for (int b = 0; b < 4; b++)
                    if (got < reads && got < 64) begin
                        rxb[got] = d[8*b +: 8];
                        got++;
                    end
            end else if (!s[1] && pushed < nw) begin
                wr(ADDR_DATA, tx_wd(t, pushed, w));
                pushed++;
            end else if (!s[0]) begin
                seen_idle = 1;
                chk("R11 deselect gap before idle",
                    32'((cyc - cs_rise_cyc) >= 2 * (baud + 1)), 32'd1);
            end
        end
        chk("R3 pulse count", 32'(rises - frame_rise0), 32'(8 * (w + reads)));
        if (fl[0]) chk("R10 rewrite ignored, pulse count", 32'(rises - frame_rise0),
                       32'(8 * (w + reads)));
        chk("R4 single select window", 32'(cs_falls - pre_falls), 32'd1);
        chk("R2 serial period", 32'(per), 32'(2 * (baud + 1)));
        for (int i = 0; i < w; i++)
            chk("R5 MOSI byte (R2 MSB first)", 32'(mosi_log[i]), 32'(tx_b(t, i)));
        chk("R4 read byte count", 32'(got), 32'(reads));
        for (int j = 0; j < got; j++)
            chk("R4 read byte", 32'(rxb[j]), 32'(resp(t, w + j)));
        rd(ADDR_XFER, d);
        chk("R6 start bit self-cleared", 32'(d[0]), 32'd0);
    endtask

    initial begin
        wait (cyc > 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, s;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 cs_n high", 32'(spi_cs_n), 32'd1);
        chk("R1 sclk low", 32'(spi_sclk), 32'd0);
        rd(ADDR_STATUS, s);
        chk("R1 status clear", s, 32'd0);
        rd(ADDR_XFER, d);
        chk("R1 transfer reg clear", d, 32'd0);

        for (int v = 0; v < NV; v++) begin
            run(v + 1, VEC[v][24], int'(VEC[v][23:16]), int'(VEC[v][15:8]),
                int'(VEC[v][7:0]), VEC[v][39:32]);
        end

        // R7: depth and discard of an extra push
        for (int k = 0; k < 5; k++) wr(ADDR_DATA, tx_wd(20, k, 20));
        rd(ADDR_STATUS, s);
        chk("R7 tx full after four pushes", 32'(s[1]), 32'd1);
        cur_t = 20;
        wr(ADDR_CLKDIV, 32'd0);
        wr(ADDR_XFER, {8'h00, 8'h00, 8'd15, 6'h00, 1'b0, 1'b1});
        s = 32'd1;
        while (s[0]) rd(ADDR_STATUS, s);
        for (int i = 0; i < 16; i++)
            chk("R7 first four words sent", 32'(mosi_log[i]), 32'(tx_b(20, i)));
        for (int k = 0; k < 3; k++) wr(ADDR_DATA, 32'h1111_1111 * k);
        rd(ADDR_STATUS, s);
        chk("R7 fifth word was dropped", 32'(s[1]), 32'd0);

        // R9: soft reset flushes the stale TX words
        wr(ADDR_CTRL, 32'd1);
        rd(ADDR_STATUS, s);
        chk("R9 status after soft reset", s, 32'd0);
        run(30, 1'b0, 4, 0, 1, 8'h00);

        // R9: soft reset in the middle of a transfer
        for (int k = 0; k < 4; k++) wr(ADDR_DATA, tx_wd(31, k, 16));
        cur_t = 31;
        wr(ADDR_CLKDIV, 32'd3);
        wr(ADDR_XFER, {8'h00, 8'h00, 8'd15, 6'h00, 1'b0, 1'b1});
        repeat (60) @(negedge clk);
        rd(ADDR_STATUS, s);
        chk("R9 busy before abort", 32'(s[0]), 32'd1);
        wr(ADDR_CTRL, 32'd1);
        chk("R9 cs_n high after abort", 32'(spi_cs_n), 32'd1);
        chk("R9 sclk low after abort", 32'(spi_sclk), 32'd0);
        rd(ADDR_STATUS, s);
        chk("R9 status clear after abort", s, 32'd0);

        // R9: soft reset empties the receive queue
        cur_t = 32;
        wr(ADDR_CLKDIV, 32'd0);
        wr(ADDR_DATA, tx_wd(32, 0, 1));
        wr(ADDR_XFER, {8'h00, 8'd7, 8'd0, 6'h00, 1'b1, 1'b1});
        s = 32'd1;
        while (s[0]) rd(ADDR_STATUS, s);
        chk("R9 rx data waiting", 32'(s[2]), 32'd1);
        wr(ADDR_CTRL, 32'd1);
        rd(ADDR_STATUS, s);
        chk("R9 rx queue flushed", s, 32'd0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule